// File: doc/BRIEF.md
# Channel-Routed Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt sources and turns them into two host lines: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Every source has a pending flag, an enable flag and an eight-bit channel number. The sources are grouped 32 to a word. Channels 0 and 1 lead to the fast line. Any channel of 2 or above leads to the normal line. A global enable and a two-bit host enable gate both lines.

Software reaches the block through a plain 32-bit register port. It uses byte offsets that must be word aligned. A write takes effect at the clock edge on which `req_i` and `we_i` are both high. A read is combinational from `addr_i`. Enables are never written directly: separate set and clear words change them, so a bit written as 0 has no effect. Pending flags are cleared by writing 1s, and a source that is still high sets its flag again.

Top module: `chan_intc`

## Requirements
- R1: After reset, every register reads zero, and `irq_o` and `fiq_o` are low.
- R2: A pending flag is set at the clock edge following any cycle in which its source is high. Flag n reads as bit (n mod 32) of the word at 0x280 + 4*(n/32). Bits beyond the last source read 0.
- R3: Writing a 1 to a bit at 0x280 + 4*g clears that flag. 0 bits leave their flags unchanged. If the source is high in the same cycle as the clear, the flag stays set.
- R4: Writing a 1 to a bit at 0x300 + 4*g enables that source. 0 bits have no effect. Reading either 0x300 + 4*g or 0x380 + 4*g returns the enable bits of group g.
- R5: Writing a 1 to a bit at 0x380 + 4*g disables that source. 0 bits have no effect.
- R6: Source n keeps its channel number in byte lane (n mod 4), bits [8*(n mod 4)+7 : 8*(n mod 4)], of the word at 0x400 + 4*(n/4). A full-word write sets it, and a read returns it.
- R7: `irq_o` = global enable AND host-enable bit 1 AND (some source has its flag set, is enabled, and has a channel of 2 or above).
- R8: `fiq_o` = global enable AND host-enable bit 0 AND (some source has its flag set, is enabled, and has channel 0 or 1).
- R9: The global enable is bit 0 of the word at 0x10. The host enable is bits [1:0] at 0x1500. When the global enable is clear, both outputs are low.
- R10: The control word at 0x4 stores all 32 written bits and reads them back. Only plain operation exists, and the control value has no effect on the outputs.
- R11: Offsets not listed above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 13 | Byte offset, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| irq_o | output | 1 | Normal host interrupt |
| fiq_o | output | 1 | Fast host interrupt |

## Verification
The bench builds the block with NUM_SRC = 40. This gives one full group and a second group that holds only eight sources, so it can check that pad bits in the upper group read zero. The bench drives sources in both groups and in every byte lane of the channel map, including the last source, 39. It also covers a clear that lands while the source is still high, and gating of each output by its own host-enable bit and by the global bit.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned GRP_W  = 32;
  localparam int unsigned CH_W   = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 13'h0004;
  localparam logic [ADDR_W-1:0] OFS_GLB  = 13'h0010;
  localparam logic [ADDR_W-1:0] OFS_STAT = 13'h0280;
  localparam logic [ADDR_W-1:0] OFS_ENS  = 13'h0300;
  localparam logic [ADDR_W-1:0] OFS_ENC  = 13'h0380;
  localparam logic [ADDR_W-1:0] OFS_MAP  = 13'h0400;
  localparam logic [ADDR_W-1:0] OFS_HEN  = 13'h1500;
endpackage

// File: rtl/intc_regdec.sv
module intc_regdec
  import intc_pkg::*;
#(
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned NUM_WRD = 10
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_ctrl_o,
  output logic              wr_glb_o,
  output logic              wr_hen_o,
  output logic [NUM_GRP-1:0] clr_stat_o,
  output logic [NUM_GRP-1:0] set_en_o,
  output logic [NUM_GRP-1:0] clr_en_o,
  output logic [NUM_WRD-1:0] wr_map_o
);
  logic wr;
  assign wr        = req_i & we_i;
  assign wr_ctrl_o = wr & (addr_i == OFS_CTRL);
  assign wr_glb_o  = wr & (addr_i == OFS_GLB);
  assign wr_hen_o  = wr & (addr_i == OFS_HEN);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4 * g);
    assign clr_stat_o[g] = wr & (addr_i == OFS_STAT + STEP);
    assign set_en_o[g]   = wr & (addr_i == OFS_ENS + STEP);
    assign clr_en_o[g]   = wr & (addr_i == OFS_ENC + STEP);
  end

  for (genvar w = 0; w < NUM_WRD; w++) begin : g_wrd
    assign wr_map_o[w] = wr & (addr_i == OFS_MAP + ADDR_W'(4 * w));
  end
endmodule

// File: rtl/intc_src_cell.sv
module intc_src_cell
  import intc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            src_i,
  input  logic            clr_i,
  input  logic            en_set_i,
  input  logic            en_clr_i,
  input  logic            map_we_i,
  input  logic [CH_W-1:0] map_d_i,
  output logic            stat_o,
  output logic            en_o,
  output logic [CH_W-1:0] chan_o,
  output logic            irq_req_o,
  output logic            fiq_req_o
);
  logic            stat_q, en_q;
  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
      chan_q <= '0;
    end else begin
      // a live source wins over a same-cycle clear
      stat_q <= (stat_q & ~clr_i) | src_i;
      if (en_set_i)      en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
      if (map_we_i) chan_q <= map_d_i;
    end
  end

  logic act;
  assign act       = stat_q & en_q;
  assign irq_req_o = act & (|chan_q[CH_W-1:1]);
  assign fiq_req_o = act & ~(|chan_q[CH_W-1:1]);
  assign stat_o    = stat_q;
  assign en_o      = en_q;
  assign chan_o    = chan_q;
endmodule

// File: rtl/chan_intc.sv
module chan_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [12:0]        addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int unsigned NUM_GRP = (NUM_SRC + GRP_W - 1) / GRP_W;
  localparam int unsigned NUM_WRD = (NUM_SRC + 3) / 4;

  logic               wr_ctrl, wr_glb, wr_hen;
  logic [NUM_GRP-1:0] clr_stat, set_en, clr_en;
  logic [NUM_WRD-1:0] wr_map;

  intc_regdec #(.NUM_GRP(NUM_GRP), .NUM_WRD(NUM_WRD)) dec_i (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wr_ctrl_o(wr_ctrl), .wr_glb_o(wr_glb), .wr_hen_o(wr_hen),
    .clr_stat_o(clr_stat), .set_en_o(set_en), .clr_en_o(clr_en),
    .wr_map_o(wr_map)
  );

  logic [31:0] ctrl_q;
  logic        glb_q;
  logic [1:0]  hen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      glb_q  <= 1'b0;
      hen_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_glb)  glb_q  <= wdata_i[0];
      if (wr_hen)  hen_q  <= wdata_i[1:0];
    end
  end

  logic [NUM_SRC-1:0]      stat_q, en_q, irq_req, fiq_req;
  logic [NUM_SRC*CH_W-1:0] chan_q;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int unsigned G = n / GRP_W;
    localparam int unsigned B = n % GRP_W;
    localparam int unsigned W = n / 4;
    localparam int unsigned L = n % 4;
    intc_src_cell cell_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i[n]),
      .clr_i(clr_stat[G] & wdata_i[B]),
      .en_set_i(set_en[G] & wdata_i[B]),
      .en_clr_i(clr_en[G] & wdata_i[B]),
      .map_we_i(wr_map[W]),
      .map_d_i(wdata_i[L*CH_W +: CH_W]),
      .stat_o(stat_q[n]), .en_o(en_q[n]),
      .chan_o(chan_q[n*CH_W +: CH_W]),
      .irq_req_o(irq_req[n]), .fiq_req_o(fiq_req[n])
    );
  end

  assign irq_o = glb_q & hen_q[1] & (|irq_req);
  assign fiq_o = glb_q & hen_q[0] & (|fiq_req);

  logic [NUM_GRP*GRP_W-1:0] stat_pad, en_pad;
  logic [NUM_WRD*32-1:0]    chan_pad;

  always_comb begin
    stat_pad = '0;
    en_pad   = '0;
    chan_pad = '0;
    stat_pad[NUM_SRC-1:0]      = stat_q;
    en_pad[NUM_SRC-1:0]        = en_q;
    chan_pad[NUM_SRC*CH_W-1:0] = chan_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CTRL) rdata_o = ctrl_q;
    if (addr_i == OFS_GLB)  rdata_o = {31'd0, glb_q};
    if (addr_i == OFS_HEN)  rdata_o = {30'd0, hen_q};
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr_i == OFS_STAT + ADDR_W'(4 * g)) rdata_o = stat_pad[g*GRP_W +: GRP_W];
      if (addr_i == OFS_ENS + ADDR_W'(4 * g) || addr_i == OFS_ENC + ADDR_W'(4 * g))
        rdata_o = en_pad[g*GRP_W +: GRP_W];
    end
    for (int w = 0; w < NUM_WRD; w++) begin
      if (addr_i == OFS_MAP + ADDR_W'(4 * w)) rdata_o = chan_pad[w*32 +: 32];
    end
  end
endmodule

// File: rtl/chan_intc_chk.sv
module chan_intc_chk #(
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               glb_q,
  input logic [1:0]         hen_q
);
  // R2
  src_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((stat_q & $past(src_i)) == $past(src_i)));

  // R3
  no_write_keeps_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R5
  enable_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(en_q));

  // R7
  irq_needs_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (hen_q[1] && ((stat_q & en_q) != '0)));

  // R8
  fiq_needs_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (hen_q[0] && ((stat_q & en_q) != '0)));

  // R9
  global_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_q |-> (!irq_o && !fiq_o));
endmodule

bind chan_intc chan_intc_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o),
  .stat_q(stat_q), .en_q(en_q), .glb_q(glb_q), .hen_q(hen_q)
);

// File: tb/chan_intc_tb_top.sv
`timescale 1ns/1ps
module chan_intc_tb_top;
  localparam int unsigned NS = 40;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [12:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NS-1:0] src_i = '0;
  logic          irq_o, fiq_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  chan_intc #(.NUM_SRC(NS)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input string tag, input logic [12:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(tag, rdata_o, exp);
  endtask

  task automatic pulse_src(input int s);
    @(negedge clk_i);
    src_i[s] = 1'b1;
    @(negedge clk_i);
    src_i[s] = 1'b0;
  endtask

  task automatic outs(input string tag, input logic ei, input logic ef);
    @(negedge clk_i);
    #1;
    chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, ei});
    chk({tag, " fiq"}, {31'd0, fiq_o}, {31'd0, ef});
  endtask

  task automatic t_reset;
    rd("R1 stat0", 13'h280, 0);
    rd("R1 stat1", 13'h284, 0);
    rd("R1 en0", 13'h300, 0);
    rd("R1 ctrl", 13'h004, 0);
    rd("R1 glb", 13'h010, 0);
    rd("R1 hen", 13'h1500, 0);
    rd("R1 map", 13'h400, 0);
    outs("R1", 1'b0, 1'b0);
  endtask

  task automatic t_status;
    pulse_src(5);
    pulse_src(39);
    rd("R2 g0", 13'h280, 32'h20);
    rd("R2 g1 pad", 13'h284, 32'h80);
    wr(13'h280, 32'h0);
    rd("R3 zero write", 13'h280, 32'h20);
    @(negedge clk_i);
    src_i[5] = 1'b1;
    wr(13'h280, 32'h20);
    rd("R3 clear vs live", 13'h280, 32'h20);
    src_i[5] = 1'b0;
    @(negedge clk_i);
    wr(13'h280, 32'h20);
    rd("R3 cleared", 13'h280, 32'h0);
    wr(13'h284, 32'h80);
    rd("R3 g1 cleared", 13'h284, 32'h0);
  endtask

  task automatic t_enable;
    wr(13'h300, 32'h0000_00F0);
    rd("R4 set", 13'h300, 32'hF0);
    rd("R4 via clr addr", 13'h380, 32'hF0);
    wr(13'h300, 32'h0);
    rd("R4 zero write", 13'h300, 32'hF0);
    wr(13'h380, 32'h0000_0030);
    rd("R5 clr", 13'h300, 32'hC0);
    wr(13'h380, 32'h0);
    rd("R5 zero write", 13'h300, 32'hC0);
    wr(13'h304, 32'hFFFF_FFFF);
    rd("R4 g1 pad", 13'h384, 32'hFF);
    wr(13'h384, 32'hFFFF_FFFF);
    rd("R5 g1 clr", 13'h304, 32'h0);
  endtask

  task automatic t_map;
    wr(13'h404, 32'h1F02_0100);
    rd("R6 word1", 13'h404, 32'h1F02_0100);
    wr(13'h424, 32'h0300_0000);
    rd("R6 src39 lane3", 13'h424, 32'h0300_0000);
    rd("R6 word0 untouched", 13'h400, 32'h0);
  endtask

  task automatic t_route;
    // source 4 -> ch0, 5 -> ch1, 6 -> ch2, 7 -> ch31 (from t_map); 6,7 enabled
    wr(13'h010, 32'h1);
    wr(13'h1500, 32'h3);
    pulse_src(6);
    outs("R7 ch2", 1'b1, 1'b0);
    wr(13'h1500, 32'h1);
    outs("R7 host bit1 off", 1'b0, 1'b0);
    wr(13'h1500, 32'h3);
    wr(13'h280, 32'h40);
    outs("R7 cleared", 1'b0, 1'b0);
    pulse_src(4);
    outs("R7 disabled src4", 1'b0, 1'b0);
    wr(13'h300, 32'h10);
    outs("R8 ch0", 1'b0, 1'b1);
    wr(13'h1500, 32'h2);
    outs("R8 host bit0 off", 1'b0, 1'b0);
    wr(13'h1500, 32'h3);
    pulse_src(7);
    outs("R7 R8 both", 1'b1, 1'b1);
    wr(13'h010, 32'h0);
    outs("R9 global off", 1'b0, 1'b0);
    rd("R9 glb read", 13'h010, 32'h0);
    rd("R9 hen read", 13'h1500, 32'h3);
    wr(13'h010, 32'h1);
    outs("R9 global on", 1'b1, 1'b1);
    wr(13'h280, 32'hFFFF_FFFF);
    outs("R3 clear all", 1'b0, 1'b0);
  endtask

  task automatic t_ctrl;
    wr(13'h004, 32'hA5A5_0003);
    rd("R10 ctrl", 13'h004, 32'hA5A5_0003);
    pulse_src(6);
    outs("R10 no effect", 1'b1, 1'b0);
    wr(13'h004, 32'h0);
    rd("R10 ctrl zero", 13'h004, 32'h0);
    wr(13'h280, 32'h40);
  endtask

  task automatic t_unmapped;
    wr(13'h0008, 32'hFFFF_FFFF);
    wr(13'h0288, 32'hFFFF_FFFF);
    rd("R11 read 0x008", 13'h008, 32'h0);
    rd("R11 read 0x288", 13'h288, 32'h0);
    rd("R11 ctrl intact", 13'h004, 32'h0);
    rd("R11 en intact", 13'h300, 32'hD0);
    outs("R11", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_status();
    t_enable();
    t_map();
    t_route();
    t_ctrl();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule